// File: doc/BRIEF.md
# Multiply-Accumulate Unit with High/Low Accumulator

This block keeps a 64-bit running sum held as a high word and a low word, and updates it from decoded 32-bit instruction words. Three accumulate operations exist: add the product of two register operands, subtract that product, and add the product of operand A and a sign-extended 16-bit immediate. In every case only the low 32 bits of the product are kept. That truncated product is then sign-extended to 64 bits before it is combined with the running sum.

A fourth operation reads the low word out and zeroes the whole accumulator. The read value appears on a registered output together with a one-cycle valid strobe. A pipeline issues at most one word per cycle with `op_valid`. Words that decode to none of the four operations have no effect. Writing the read value back to a register file is the caller's job.

Top module: `mac_hilo_unit`

## Requirements
- R1: Multiply-add is main opcode 0x31 (word bits 31:26) with sub-code 1 in bits 3:0. The low 32 bits of opnd_a*opnd_b are sign-extended to 64 bits and added to the accumulator, so a product whose true value needs more than 32 bits contributes only its truncated, sign-extended part.
- R2: Multiply-subtract is main opcode 0x31 with sub-code 2 in bits 3:0. The same truncated, sign-extended product is subtracted from the accumulator.
- R3: Immediate multiply-add is main opcode 0x13. The 16-bit immediate is sign-extended to 32 bits, multiplied by opnd_a, truncated and sign-extended as in R1, and added. opnd_b is not used.
- R4: Read-and-clear is main opcode 0x06 with word bit 16 set. It returns the accumulator's low word on rd_data and sets the whole 64-bit accumulator to zero, so a second read with nothing in between returns 0.
- R5: rd_valid is high for exactly the one cycle that follows a read-and-clear issue, and low in every other cycle.
- R6: A read-and-clear issued in the cycle right after an accumulate returns a value that includes that accumulate.
- R7: The accumulator does not change and rd_valid stays low in these cases: op_valid is low, the main opcode is none of 0x31, 0x13 or 0x06, opcode 0x31 carries a sub-code other than 1 or 2, or opcode 0x06 has bit 16 clear.
- R8: A synchronous active-low reset zeroes the accumulator and drives rd_valid low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| op_valid | input | 1 | insn_word is issued this cycle |
| insn_word | input | 32 | Instruction word to decode |
| opnd_a | input | XLEN | Register operand A |
| opnd_b | input | XLEN | Register operand B |
| imm16 | input | IMM_W | Immediate for the immediate multiply-add |
| rd_data | output | XLEN | Low word returned by the last read-and-clear |
| rd_valid | output | 1 | rd_data is new this cycle |

## Verification
An accumulate issued before a clock edge has updated the accumulator by that same edge. A read-and-clear issued before an edge drives rd_data and rd_valid from that edge on, so every result is due one edge after its issue. The bench drives each word on a falling edge and samples the outputs shortly after the next rising edge. It compares them with a 64-bit model that it advances on the same edge. Vectors issue on consecutive cycles, which also covers a read that directly follows an accumulate.

// File: rtl/mac_pkg.sv
// Package: shared field positions, code values and the decoded operation
// type for the multiply-accumulate unit.
// Assumes a 32-bit instruction word with the main opcode in the top six bits.
package mac_pkg;
    localparam int INSN_W     = 32;
    localparam int OPC_HI     = 31;
    localparam int OPC_LO     = 26;
    localparam int OPC_W      = OPC_HI - OPC_LO + 1;
    localparam int RDSEL_BIT  = 16;
    localparam int SUBC_HI    = 3;
    localparam int SUBC_LO    = 0;
    localparam int SUBC_W     = SUBC_HI - SUBC_LO + 1;

    localparam logic [OPC_W-1:0]  OPC_ACC_IMM = 6'h13;
    localparam logic [OPC_W-1:0]  OPC_ACC_REG = 6'h31;
    localparam logic [OPC_W-1:0]  OPC_RD_GRP  = 6'h06;
    localparam logic [SUBC_W-1:0] SUBC_ADD    = 4'h1;
    localparam logic [SUBC_W-1:0] SUBC_SUB    = 4'h2;

    typedef enum logic [2:0] {
        MOP_NONE  = 3'd0,
        MOP_MADD  = 3'd1,
        MOP_MSUB  = 3'd2,
        MOP_MADDI = 3'd3,
        MOP_READ  = 3'd4
    } mac_op_e;
endpackage

// File: rtl/mac_decode.sv
// Module: mac_decode
// Turns an issued instruction word into one of the accumulator operations.
// Assumes at most one word per cycle. Anything unrecognised maps to MOP_NONE.
module mac_decode
    import mac_pkg::*;
(
    input  logic              op_valid,
    input  logic [INSN_W-1:0] insn_word,
    output mac_op_e           op
);
    logic [OPC_W-1:0]  opc;
    logic [SUBC_W-1:0] subc;

    assign opc  = insn_word[OPC_HI:OPC_LO];
    assign subc = insn_word[SUBC_HI:SUBC_LO];

    // Select the operation from the main opcode, then the sub-field.
    always_comb begin
        op = MOP_NONE;
        if (op_valid) begin
            unique case (opc)
                OPC_ACC_IMM: op = MOP_MADDI;
                OPC_ACC_REG: begin
                    if (subc == SUBC_ADD)      op = MOP_MADD;
                    else if (subc == SUBC_SUB) op = MOP_MSUB;
                end
                OPC_RD_GRP: begin
                    if (insn_word[RDSEL_BIT]) op = MOP_READ;
                end
                default: op = MOP_NONE;
            endcase
        end
    end
endmodule

// File: rtl/mac_product.sv
// Module: mac_product
// Single-cycle multiplier. It forms the truncated product of operand A and
// either operand B or the sign-extended immediate, then sign-extends that
// product to accumulator width.
// Assumes IMM_W <= XLEN.
module mac_product
    import mac_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int IMM_W = 16,
    localparam int ACC_W = 2 * XLEN
) (
    input  mac_op_e           op,
    input  logic [XLEN-1:0]   opnd_a,
    input  logic [XLEN-1:0]   opnd_b,
    input  logic [IMM_W-1:0]  imm,
    output logic [ACC_W-1:0]  prod_ext
);
    logic [XLEN-1:0] imm_ext;
    logic [XLEN-1:0] mul_b;
    logic [XLEN-1:0] prod_lo;

    // Widen the immediate by sign; no widening is needed when the widths match.
    generate
        if (IMM_W < XLEN) begin : g_imm_sext
            assign imm_ext = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
        end else begin : g_imm_full
            assign imm_ext = imm;
        end
    endgenerate

    // Choose the second factor, keep the low word of the product, sign-extend it.
    always_comb begin
        mul_b    = (op == MOP_MADDI) ? imm_ext : opnd_b;
        prod_lo  = opnd_a * mul_b;
        prod_ext = {{XLEN{prod_lo[XLEN-1]}}, prod_lo};
    end
endmodule

// File: rtl/mac_accum.sv
// Module: mac_accum
// Holds the 64-bit high/low accumulator and the registered read-out.
// Assumes one operation per cycle. A read takes the value held before this
// edge, which already includes any accumulate from the previous cycle.
module mac_accum
    import mac_pkg::*;
#(
    parameter int XLEN  = 32,
    localparam int ACC_W = 2 * XLEN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  mac_op_e           op,
    input  logic [ACC_W-1:0]  prod_ext,
    output logic [ACC_W-1:0]  acc_q,
    output logic [XLEN-1:0]   rd_data,
    output logic              rd_valid
);
    // Update the accumulator and the read-out register once per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q    <= '0;
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= (op == MOP_READ);
            unique case (op)
                MOP_MADD, MOP_MADDI: acc_q <= acc_q + prod_ext;
                MOP_MSUB:            acc_q <= acc_q - prod_ext;
                MOP_READ: begin
                    rd_data <= acc_q[XLEN-1:0];
                    acc_q   <= '0;
                end
                default:             acc_q <= acc_q;
            endcase
        end
    end
endmodule

// File: rtl/mac_hilo_unit.sv
// Module: mac_hilo_unit (top)
// Multiply-accumulate unit with a 64-bit high/low accumulator. It provides
// multiply-add, multiply-subtract, immediate multiply-add and read-and-clear.
// Assumes the caller handles register writeback and any stalls.
module mac_hilo_unit
    import mac_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int IMM_W = 16,
    localparam int ACC_W = 2 * XLEN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [INSN_W-1:0] insn_word,
    input  logic [XLEN-1:0]   opnd_a,
    input  logic [XLEN-1:0]   opnd_b,
    input  logic [IMM_W-1:0]  imm16,
    output logic [XLEN-1:0]   rd_data,
    output logic              rd_valid
);
    mac_op_e          op;
    logic [ACC_W-1:0] prod_ext;
    logic [ACC_W-1:0] acc_q;

    mac_decode u_dec (
        .op_valid  (op_valid),
        .insn_word (insn_word),
        .op        (op)
    );

    mac_product #(.XLEN(XLEN), .IMM_W(IMM_W)) u_mul (
        .op       (op),
        .opnd_a   (opnd_a),
        .opnd_b   (opnd_b),
        .imm      (imm16),
        .prod_ext (prod_ext)
    );

    mac_accum #(.XLEN(XLEN)) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (op),
        .prod_ext (prod_ext),
        .acc_q    (acc_q),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );
endmodule

// File: rtl/mac_hilo_checker.sv
// Module: mac_hilo_checker
// Temporal checks on the multiply-accumulate unit, attached by bind.
// Assumes the accumulator state of the top is visible as acc_q.
module mac_hilo_checker
    import mac_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int IMM_W = 16,
    localparam int ACC_W = 2 * XLEN
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic [INSN_W-1:0] insn_word,
    input logic [XLEN-1:0]   opnd_a,
    input logic [XLEN-1:0]   opnd_b,
    input logic [IMM_W-1:0]  imm16,
    input logic [XLEN-1:0]   rd_data,
    input logic              rd_valid,
    input logic [ACC_W-1:0]  acc_q
);
    logic            is_read, is_madd, is_msub, is_maddi;
    logic [XLEN-1:0] reg_prod, imm_prod, imm_wide;

    assign is_read  = op_valid && insn_word[OPC_HI:OPC_LO] == OPC_RD_GRP && insn_word[RDSEL_BIT];
    assign is_madd  = op_valid && insn_word[OPC_HI:OPC_LO] == OPC_ACC_REG
                      && insn_word[SUBC_HI:SUBC_LO] == SUBC_ADD;
    assign is_msub  = op_valid && insn_word[OPC_HI:OPC_LO] == OPC_ACC_REG
                      && insn_word[SUBC_HI:SUBC_LO] == SUBC_SUB;
    assign is_maddi = op_valid && insn_word[OPC_HI:OPC_LO] == OPC_ACC_IMM;
    assign imm_wide = XLEN'($signed(imm16));
    assign reg_prod = opnd_a * opnd_b;
    assign imm_prod = opnd_a * imm_wide;

    AST_MADD_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        is_madd |=> acc_q == $past(acc_q) + {{XLEN{$past(reg_prod[XLEN-1])}}, $past(reg_prod)}); // R1
    AST_MSUB_DIFF: assert property (@(posedge clk) disable iff (!rst_n)
        is_msub |=> acc_q == $past(acc_q) - {{XLEN{$past(reg_prod[XLEN-1])}}, $past(reg_prod)}); // R2
    AST_MADDI_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        is_maddi |=> acc_q == $past(acc_q) + {{XLEN{$past(imm_prod[XLEN-1])}}, $past(imm_prod)}); // R3
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        is_read |=> (acc_q == '0) && (rd_data == $past(acc_q[XLEN-1:0]))); // R4
    AST_READ_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        is_read |=> rd_valid); // R5
    AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !is_read |=> !rd_valid); // R5
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(is_read || is_madd || is_msub || is_maddi) |=> $stable(acc_q)); // R7
endmodule

bind mac_hilo_unit mac_hilo_checker #(.XLEN(XLEN), .IMM_W(IMM_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .insn_word (insn_word),
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .imm16     (imm16),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid),
    .acc_q     (acc_q)
);

// File: tb/tb_mac_hilo_unit.sv
`timescale 1ns/1ps
// Bench: walks a vector table through a 64-bit model, then runs directed
// tests for reset and for ignored issues.
module tb_mac_hilo_unit;
    localparam int XLEN = 32;
    localparam logic [31:0] W_MADD  = 32'hC400_0001;
    localparam logic [31:0] W_MSUB  = 32'hC400_0002;
    localparam logic [31:0] W_MADDI = 32'h4C00_0000;
    localparam logic [31:0] W_READ  = 32'h1801_0000;
    localparam logic [31:0] W_MOVE  = 32'h1800_0000;
    localparam logic [31:0] W_BADSC = 32'hC400_0003;
    localparam logic [31:0] W_OTHER = 32'h0000_0000;
    localparam int K_NONE = 0, K_ADD = 1, K_SUB = 2, K_ADDI = 3, K_RD = 4;
    localparam int NVEC = 14;
    // Fields: kind[2:0], word, a, b, imm.
    localparam logic [114:0] VEC [NVEC] = '{
        {3'(K_ADD),  W_MADD,  32'd3,          32'd5,       16'h0000},
        {3'(K_ADD),  W_MADD,  32'hFFFF_FFFF,  32'd7,       16'h0000},
        {3'(K_RD),   W_READ,  32'd0,          32'd0,       16'h0000},
        {3'(K_RD),   W_READ,  32'd0,          32'd0,       16'h0000},
        {3'(K_SUB),  W_MSUB,  32'd4,          32'd6,       16'h0000},
        {3'(K_ADDI), W_MADDI, 32'd10,         32'd99,      16'hFFFE},
        {3'(K_RD),   W_READ,  32'd0,          32'd0,       16'h0000},
        {3'(K_ADD),  W_MADD,  32'h0001_0000,  32'h0001_0000, 16'h0000},
        {3'(K_ADD),  W_MADD,  32'h4000_0000,  32'd2,       16'h0000},
        {3'(K_NONE), W_MOVE,  32'd1,          32'd1,       16'h0000},
        {3'(K_NONE), W_BADSC, 32'd9,          32'd9,       16'h0000},
        {3'(K_NONE), W_OTHER, 32'd5,          32'd5,       16'h0000},
        {3'(K_ADDI), W_MADDI, 32'd2,          32'd0,       16'h7FFF},
        {3'(K_RD),   W_READ,  32'd0,          32'd0,       16'h0000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [31:0] insn_word = '0;
    logic [31:0] opnd_a = '0, opnd_b = '0;
    logic [15:0] imm16 = '0;
    logic [31:0] rd_data;
    logic        rd_valid;
    int          checks = 0, errors = 0;
    logic [63:0] model = '0;
    logic [31:0] exp_rd = '0;
    logic        done = 1'b0;

    always #2.5 clk = ~clk;

    mac_hilo_unit dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .insn_word(insn_word),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .imm16(imm16),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Issue one word, advance the model and check the outputs after the edge.
    task automatic issue(input int kind, input logic v, input logic [31:0] w,
                         input logic [31:0] a, input logic [31:0] b,
                         input logic [15:0] im, input string req);
        logic [31:0] p;
        @(negedge clk);
        op_valid = v; insn_word = w; opnd_a = a; opnd_b = b; imm16 = im;
        if (v) begin
            case (kind)
                K_ADD:  begin p = a * b; model = model + {{32{p[31]}}, p}; end
                K_SUB:  begin p = a * b; model = model - {{32{p[31]}}, p}; end
                K_ADDI: begin p = a * {{16{im[15]}}, im}; model = model + {{32{p[31]}}, p}; end
                K_RD:   begin exp_rd = model[31:0]; model = '0; end
                default: ;
            endcase
        end
        @(posedge clk); #1;
        chk({req, " strobe"}, {31'd0, rd_valid}, {31'd0, (v && kind == K_RD)});
        if (v && kind == K_RD) chk({req, " data"}, rd_data, exp_rd);
    endtask

    initial begin
        // R8: reset state.
        repeat (3) @(posedge clk);
        #1 chk("R8 reset strobe", {31'd0, rd_valid}, 32'd0);
        @(negedge clk); rst_n = 1'b1;
        // Walk the table back to back; vectors 2 and 13 read right after an accumulate (R6).
        for (int i = 0; i < NVEC; i++) begin
            issue(int'(VEC[i][114:112]), 1'b1, VEC[i][111:80], VEC[i][79:48],
                  VEC[i][47:16], VEC[i][15:0], "R1/R2/R3/R4/R5/R6 table");
        end
        // R6: read directly after a multiply-subtract sees it.
        issue(K_SUB, 1'b1, W_MSUB, 32'd3, 32'd3, 16'h0, "R2");
        issue(K_RD, 1'b1, W_READ, 0, 0, 16'h0, "R6");
        if (exp_rd !== 32'hFFFF_FFF7) chk("R6 model", exp_rd, 32'hFFFF_FFF7);
        // R7: a valid accumulate word with op_valid low has no effect.
        issue(K_ADD, 1'b1, W_MADD, 32'd6, 32'd7, 16'h0, "R1");
        issue(K_ADD, 1'b0, W_MADD, 32'd100, 32'd100, 16'h0, "R7 idle");
        issue(K_RD, 1'b0, W_READ, 0, 0, 16'h0, "R7 idle read");
        issue(K_RD, 1'b1, W_READ, 0, 0, 16'h0, "R7");
        chk("R7 unchanged", rd_data, 32'd42);
        // R4: clear leaves zero for the next read.
        issue(K_RD, 1'b1, W_READ, 0, 0, 16'h0, "R4 clear");
        // R3: immediate form ignores operand B.
        issue(K_ADDI, 1'b1, W_MADDI, 32'd3, 32'hDEAD_BEEF, 16'h8000, "R3");
        issue(K_RD, 1'b1, W_READ, 0, 0, 16'h0, "R3");
        chk("R3 value", rd_data, 32'hFFFE_8000);
        // R8: mid-run reset discards the accumulated value.
        issue(K_ADD, 1'b1, W_MADD, 32'd11, 32'd11, 16'h0, "R1");
        @(negedge clk); rst_n = 1'b0; op_valid = 1'b0;
        @(posedge clk); #1;
        chk("R8 strobe low", {31'd0, rd_valid}, 32'd0);
        @(negedge clk); rst_n = 1'b1; model = '0;
        issue(K_RD, 1'b1, W_READ, 0, 0, 16'h0, "R8 post-reset");
        chk("R8 cleared", rd_data, 32'd0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: ends a hung run as a failure.
    initial begin
        #100000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule